// File: doc/BRIEF.md
# Programmable-Polynomial CRC Accelerator

This block computes a running cyclic redundancy checksum over a stream of 32-bit words that arrive as writes on a small register bus. Software first writes a control word (enable, bit order, input mirroring), then the polynomial and a seed. After that, each write to the data register folds one more word into the checksum. A DMA engine feeds data with back-to-back writes on the same bus. The checksum register always holds the CRC of every word accepted so far. Final XOR, output reflection and comparison with an expected signature are left to software.

Any polynomial of up to 32 bits is supported, and both bit orders are computed by the same engine. For MSB-first operation the polynomial and seed are left-justified, with the top power dropped. For LSB-first operation they are right-justified, with the polynomial given in reflected form. Each word may be mirrored before it enters the calculation: bits within each byte, bytes within the word, and the two 16-bit halves. These options are selected independently and can be combined.

A word is absorbed in a single clock cycle by a chain of 32 unrolled shift/XOR stages. The new checksum is visible on `crc_out` and on the bus one cycle after the write, and `upd_done` pulses in that same cycle.

Top module: `crc_accel`

## Requirements
- R1: After reset the control, polynomial and checksum registers read as zero and `upd_done` is low.
- R2: The register map is as follows. Address 0 is control: bit 0 enable, bit 1 LSB-first, bits [4:2] mirror select. Address 1 is the polynomial. Address 2 is the checksum/seed. Address 3 is data in. Control reads back its five bits zero-extended, the polynomial reads back as written, and address 3 reads as zero.
- R3: A write to address 2 loads the seed, and it appears on `crc_out` one cycle later.
- R4: With bit 1 clear (MSB-first), each data bit is taken from bit 31 down to bit 0. For each bit: feedback = state[31] XOR bit, then state = state << 1, then the state is XORed with the polynomial when the feedback is 1.
- R5: With bit 1 set (LSB-first), each data bit is taken from bit 0 up to bit 31. For each bit: feedback = state[0] XOR bit, then state = state >> 1, then the state is XORed with the polynomial when the feedback is 1.
- R6: Each accepted word starts from the stored checksum, so back-to-back words chain. The updated value is readable the cycle after the write. The checksum holds when no write occurs.
- R7: Control bit 2 reverses the bit order within each byte of the input word.
- R8: Control bit 3 reverses the byte order of the input word.
- R9: Control bit 4 swaps the two 16-bit halves of the input word. When several mirror bits are set they apply in the order bit, byte, half. With none set the word passes unchanged.
- R10: A data write while the enable bit is clear is ignored: the checksum does not change and `upd_done` stays low.
- R11: `upd_done` is high for exactly the cycle after each accepted data write, and low otherwise.
- R12: A polynomial shorter than 32 bits keeps its checksum justified. A 16-bit MSB-first CRC leaves bits [15:0] at zero. A 16-bit LSB-first CRC leaves bits [31:16] at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 2 | Register address for both reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| crc_out | output | 32 | Current checksum register |
| upd_done | output | 1 | Pulses the cycle after a word was absorbed |

## Verification
A wrong stage in the shift/XOR chain, or a wrong mirror path, corrupts the checksum of the very word it touches. Because the state chains, the error also persists in every later checksum until a new seed is loaded. The scoreboard compares `crc_out` with a bit-serial model in the cycle `upd_done` rises, so the first bad word is reported at once. A wrong enable or strobe decode shows up either as a missing or extra `upd_done` pulse, or as a checksum that moves during an ignored write.

// File: rtl/crc_pkg.sv
package crc_pkg;
    localparam int CRC_W   = 32;
    localparam int ADDR_W  = 2;
    localparam int MIR_W   = 3;
    localparam int CTRL_W  = 2 + MIR_W;

    localparam logic [ADDR_W-1:0] REG_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] REG_POLY = 2'd1;
    localparam logic [ADDR_W-1:0] REG_SUM  = 2'd2;
    localparam logic [ADDR_W-1:0] REG_DIN  = 2'd3;

    typedef struct packed {
        logic [MIR_W-1:0] mirror;   // [0] bits in byte, [1] bytes, [2] halves
        logic             lsb_first;
        logic             enable;
    } ctrl_t;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CRC_W-1:0] poly;
        logic [CRC_W-1:0] sum;
        logic             done;
    } crc_state_t;
endpackage

// File: rtl/crc_mirror.sv
module crc_mirror #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    input  logic [2:0]   sel,
    output logic [W-1:0] dout
);
    localparam int NBYTES = W / 8;
    localparam int HALF   = W / 2;

    logic [W-1:0] bit_rev;
    logic [W-1:0] byte_rev;
    logic [W-1:0] s1, s2;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        for (genvar k = 0; k < 8; k++) begin : g_bit
            assign bit_rev[b*8 + k] = s0_bit(b*8 + 7 - k);
        end
        assign byte_rev[b*8 +: 8] = s1[(NBYTES-1-b)*8 +: 8];
    end

    function automatic logic s0_bit(input int idx);
        return din[idx];
    endfunction

    always_comb begin
        s1   = sel[0] ? bit_rev  : din;
        s2   = sel[1] ? byte_rev : s1;
        dout = sel[2] ? {s2[HALF-1:0], s2[W-1:HALF]} : s2;
    end

    // mirroring only permutes bits (R9)
    always_comb begin
        p_perm_r9: assert ($countones(dout) == $countones(din));
    end
endmodule

// File: rtl/crc_step.sv
module crc_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] s_in,
    input  logic [W-1:0] poly,
    input  logic         dbit,
    input  logic         lsb,
    output logic [W-1:0] s_out
);
    logic fb;
    always_comb begin
        if (lsb) begin
            fb    = s_in[0] ^ dbit;
            s_out = (s_in >> 1) ^ (fb ? poly : '0);
        end else begin
            fb    = s_in[W-1] ^ dbit;
            s_out = (s_in << 1) ^ (fb ? poly : '0);
        end
    end
endmodule

// File: rtl/crc_chain.sv
module crc_chain #(
    parameter int W = 32
) (
    input  logic [W-1:0] seed,
    input  logic [W-1:0] poly,
    input  logic [W-1:0] word,
    input  logic         lsb,
    output logic [W-1:0] result
);
    localparam int HALF = W / 2;

    logic [W-1:0] stage [0:W];
    assign stage[0] = seed;

    for (genvar i = 0; i < W; i++) begin : g_stage
        logic dsel;
        assign dsel = lsb ? word[i] : word[W-1-i];
        crc_step #(.W(W)) u_step (
            .s_in (stage[i]),
            .poly (poly),
            .dbit (dsel),
            .lsb  (lsb),
            .s_out(stage[i+1])
        );
    end

    assign result = stage[W];

    // short polynomials stay justified (R12)
    always_comb begin
        p_lsb_just_r12: assert (!(lsb && poly[W-1:HALF] == '0 && seed[W-1:HALF] == '0)
                                || result[W-1:HALF] == '0);
        p_msb_just_r12: assert (!(!lsb && poly[HALF-1:0] == '0 && seed[HALF-1:0] == '0)
                                || result[HALF-1:0] == '0);
    end
endmodule

// File: rtl/crc_accel.sv
module crc_accel
    import crc_pkg::*;
#(
    parameter int DATA_W = crc_pkg::CRC_W,
    parameter int AW     = crc_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] crc_out,
    output logic              upd_done
);
    crc_state_t st_d, st_q;

    logic [DATA_W-1:0] word_m;
    logic [DATA_W-1:0] sum_nxt;
    logic              din_wr;

    crc_mirror #(.W(DATA_W)) u_mirror (
        .din (bus_wdata),
        .sel (st_q.ctrl.mirror),
        .dout(word_m)
    );

    crc_chain #(.W(DATA_W)) u_chain (
        .seed  (st_q.sum),
        .poly  (st_q.poly),
        .word  (word_m),
        .lsb   (st_q.ctrl.lsb_first),
        .result(sum_nxt)
    );

    assign din_wr = bus_we && (bus_addr == REG_DIN);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (bus_we) begin
            unique case (bus_addr)
                REG_CTRL: st_d.ctrl = ctrl_t'(bus_wdata[CTRL_W-1:0]);
                REG_POLY: st_d.poly = bus_wdata;
                REG_SUM:  st_d.sum  = bus_wdata;
                default: begin
                    if (st_q.ctrl.enable) begin
                        st_d.sum  = sum_nxt;
                        st_d.done = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (bus_addr)
            REG_CTRL: bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, st_q.ctrl};
            REG_POLY: bus_rdata = st_q.poly;
            REG_SUM:  bus_rdata = st_q.sum;
            default:  bus_rdata = '0;
        endcase
    end

    assign crc_out  = st_q.sum;
    assign upd_done = st_q.done;

    p_seed_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == REG_SUM) |=> (crc_out == $past(bus_wdata)));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(crc_out));

    p_ignore_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (din_wr && !st_q.ctrl.enable) |=> ($stable(crc_out) && !upd_done));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (din_wr && st_q.ctrl.enable) |=> upd_done);

    p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(din_wr && st_q.ctrl.enable) |=> !upd_done);
endmodule

// File: tb/test_crc_accel.sv
module test_crc_accel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, crc_out;
    logic        upd_done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [31:0] exp_q [$];

    logic [31:0] m_sum, m_poly;
    logic        m_lsb, m_en;
    logic [2:0]  m_mir;

    always #10 clk = ~clk;

    crc_accel i_crc_accel (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .crc_out(crc_out),
        .upd_done(upd_done)
    );

    function automatic logic [31:0] ref_mirror(input logic [31:0] w, input logic [2:0] m);
        logic [31:0] r;
        r = w;
        if (m[0]) begin
            logic [31:0] t;
            for (int b = 0; b < 4; b++)
                for (int k = 0; k < 8; k++)
                    t[b*8+k] = r[b*8+7-k];
            r = t;
        end
        if (m[1]) r = {r[7:0], r[15:8], r[23:16], r[31:24]};
        if (m[2]) r = {r[15:0], r[31:16]};
        return r;
    endfunction

    function automatic logic [31:0] ref_crc(input logic [31:0] s, input logic [31:0] w,
                                            input logic [31:0] p, input logic lsb);
        logic [31:0] st;
        st = s;
        for (int k = 0; k < 32; k++) begin
            logic d, fb;
            d = lsb ? w[k] : w[31-k];
            if (lsb) begin
                fb = st[0] ^ d;
                st = st >> 1;
            end else begin
                fb = st[31] ^ d;
                st = st << 1;
            end
            if (fb) st = st ^ p;
        end
        return st;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle();
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input logic [1:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1 check(req, bus_rdata, exp);
    endtask

    task automatic feed(input logic [31:0] w);
        if (m_en) begin
            m_sum = ref_crc(m_sum, ref_mirror(w, m_mir), m_poly, m_lsb);
            exp_q.push_back(m_sum);
        end
        wr(2'd3, w);
    endtask

    task automatic setup(input logic [31:0] p, input logic [31:0] seed,
                         input logic lsb, input logic [2:0] mir);
        wr(2'd0, {27'd0, mir, lsb, 1'b1});
        wr(2'd1, p);
        wr(2'd2, seed);
        idle();
        m_poly = p; m_sum = seed; m_lsb = lsb; m_mir = mir; m_en = 1'b1;
        check("R3 seed on crc_out", crc_out, seed);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && upd_done) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R11: unexpected upd_done, actual %h expected none", crc_out);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check(m_lsb ? "R5/R6/R7/R8/R9 lsb-first word" : "R4/R6/R7/R8/R9 msb-first word",
                      crc_out, e);
            end
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] polys [4];
        logic [31:0] seeds [4];
        logic        lsbs  [4];
        logic [2:0]  mirs  [5];
        logic [31:0] lfsr;
        logic [31:0] held;

        polys = '{32'h04C11DB7, 32'hEDB88320, 32'h10210000, 32'h00008408};
        seeds = '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFF0000, 32'h0000FFFF};
        lsbs  = '{1'b0, 1'b1, 1'b0, 1'b1};
        mirs  = '{3'd0, 3'd1, 3'd2, 3'd4, 3'd7};
        lfsr  = 32'h1ACE_B00C;
        m_en  = 1'b0; m_sum = '0; m_poly = '0; m_lsb = 1'b0; m_mir = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 crc_out", crc_out, 32'h0);
        check("R1 upd_done", {31'd0, upd_done}, 32'h0);
        rd_check(2'd0, 32'h0, "R1 control");
        rd_check(2'd1, 32'h0, "R1 poly");
        rd_check(2'd2, 32'h0, "R1 sum");

        // R2 register readback
        wr(2'd0, 32'hFFFF_FFFE);
        wr(2'd1, 32'hA5C3_0F1E);
        wr(2'd3, 32'h1234_5678);   // disabled: ignored (R10)
        idle();
        check("R10 no upd_done while disabled", {31'd0, upd_done}, 32'h0);
        check("R10 sum unchanged while disabled", crc_out, 32'h0);
        rd_check(2'd0, 32'h0000_001E, "R2 control readback");
        rd_check(2'd1, 32'hA5C3_0F1E, "R2 poly readback");
        rd_check(2'd3, 32'h0, "R2 data reads zero");

        // main sweep: every polynomial/order with every mirror mode
        for (int c = 0; c < 4; c++) begin
            for (int mi = 0; mi < 5; mi++) begin
                setup(polys[c], seeds[c], lsbs[c], mirs[mi]);
                feed(32'h0000_0000);
                feed(32'hFFFF_FFFF);
                feed(32'h3132_3334);
                for (int k = 0; k < 4; k++) begin
                    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                    feed(lfsr);
                end
                idle();
                idle();
                check("R11 all words scored", exp_q.size(), 32'd0);
                rd_check(2'd2, m_sum, "R6 sum readback");
                if (c == 2) check("R12 msb16 low half zero", {16'd0, crc_out[15:0]}, 32'h0);
                if (c == 3) check("R12 lsb16 high half zero", {16'd0, crc_out[31:16]}, 32'h0);
            end
        end

        // R10: disable then write data, state must hold
        held = m_sum;
        wr(2'd0, {27'd0, 3'd0, 1'b1, 1'b0});
        m_en = 1'b0;
        feed(32'hDEAD_BEEF);
        idle();
        check("R10 upd_done low on ignored word", {31'd0, upd_done}, 32'h0);
        check("R10 sum held on ignored word", crc_out, held);
        idle();
        check("R10 sum still held", crc_out, held);

        // R3 with a zero seed and zero data: checksum remains zero (R4)
        setup(32'h04C11DB7, 32'h0, 1'b0, 3'd0);
        feed(32'h0);
        idle(); idle();
        check("R4 zero in zero out", crc_out, 32'h0);

        idle();
        check("R11 queue empty at end", exp_q.size(), 32'd0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule